// File: doc/BRIEF.md
# Comparator Event and Wake Controller

This block is the digital control logic that sits beside a low-power analog comparator. The raw comparator output passes through a two-flop synchronizer. The block then watches the synchronized level for a transition of the configured polarity. A qualified transition sets a sticky event flag. The flag stays set until software clears it. Three separately gated paths use this state: a one-cycle pulse on the event fabric, a wake-from-standby request, and a pin drive that follows the comparator level.

The block also turns the two comparator input-select fields into one-hot switch enables. The positive-side field is 4 bits wide and the negative-side field is 3 bits wide. A code that does not name an input leaves every switch open. All configuration arrives as plain level inputs from a register bank elsewhere. None of the paths carries a data stream, so every port is a plain control or status pin with no valid/ready handshake.

Top module: `cmp_evt_ctrl`

## Requirements
- R1: With `cfg_edge_fall`=0 and `cfg_enable`=1, a 0-to-1 change on `cmp_raw` sets `flag_o` on the third rising clock edge after the change. The first two edges are taken by the synchronizer.
- R2: With `cfg_edge_fall`=1 and `cfg_enable`=1, a 1-to-0 change on `cmp_raw` sets `flag_o` with the same three-edge latency.
- R3: A transition of the opposite polarity to the one selected leaves `flag_o` unchanged.
- R4: `flag_o` stays set until `flag_clr`=1 is seen at a clock edge. A qualified edge in the same cycle as a clear wins, and the flag stays set.
- R5: `evt_pulse_o` is high for exactly one cycle when (`flag_o` AND `cfg_evt_en` AND `cfg_enable`) goes from 0 to 1. It is high in the cycle in which that condition first holds. With `cfg_evt_en`=0 it stays low.
- R6: `wake_req_o` equals `cfg_enable` AND `cfg_wake_en` AND the synchronized comparator level.
- R7: `pin_o` equals `cfg_enable` AND `cfg_pin_en` AND the synchronized comparator level.
- R8: `raw_level_o` shows the synchronized comparator level two clock edges after a change, whatever the enables are.
- R9: `psw_en_o` has bit (c-1) set, and only that bit, when `cfg_psel`=c for c in 1..8. For codes 0 and 9..15 it is all zero.
- R10: `nsw_en_o` has bit (c-1) set, and only that bit, when `cfg_nsel`=c for c in 1..4. For codes 0 and 5..7 it is all zero.
- R11: While `cfg_enable`=0, no transition sets `flag_o`, and `evt_pulse_o`, `wake_req_o` and `pin_o` are all 0.
- R12: After reset, `flag_o`, `evt_pulse_o`, `wake_req_o`, `pin_o` and `raw_level_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Module enable |
| cfg_edge_fall | input | 1 | 1 selects falling edges, 0 selects rising edges |
| cfg_evt_en | input | 1 | Event pulse generation enable |
| cfg_wake_en | input | 1 | Standby wake request enable |
| cfg_pin_en | input | 1 | Comparator-to-pin enable |
| cfg_psel | input | 4 | Positive input select code |
| cfg_nsel | input | 3 | Negative input select code |
| flag_clr | input | 1 | Clears the event flag (write-one strobe) |
| cmp_raw | input | 1 | Asynchronous raw comparator output |
| flag_o | output | 1 | Sticky event flag |
| evt_pulse_o | output | 1 | One-cycle event fabric pulse |
| wake_req_o | output | 1 | Wake-from-standby request |
| pin_o | output | 1 | Comparator level to the device pin |
| raw_level_o | output | 1 | Synchronized comparator level status |
| psw_en_o | output | 8 | One-hot positive input switch enables |
| nsw_en_o | output | 4 | One-hot negative input switch enables |

## Verification
The assertions assume that reset is released while `cmp_raw` is low. They also assume that the configuration inputs only change away from the clock edge, so no edge arrives without a recorded prior level. The select-decoder checks are skipped while a select code holds unknown bits. The stimulus drives every input on the falling clock edge and holds `cmp_raw` low through reset. Each transition of `cmp_raw` is held for at least three cycles, so the synchronizer pipeline settles before the next change.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;
  localparam int unsigned PSEL_W   = 4;
  localparam int unsigned PSEL_N   = 8;
  localparam int unsigned NSEL_W   = 3;
  localparam int unsigned NSEL_N   = 4;
  localparam int unsigned SYNC_LEN = 2;

  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_pol_e;
endpackage

// File: rtl/cmp_sync_edge.sv
module cmp_sync_edge
  import cmp_evt_pkg::*;
#(
  parameter int unsigned STAGES = SYNC_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic qual_en_i,
  input  logic edge_fall_i,
  output logic level_o,
  output logic edge_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic          prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[LAST-1:0], raw_i};
      prev_q  <= chain_q[LAST];
    end
  end

  edge_pol_e pol;
  logic      hit;

  always_comb begin
    pol = edge_pol_e'(edge_fall_i);
    unique case (pol)
      EDGE_RISE: hit = chain_q[LAST] & ~prev_q;
      EDGE_FALL: hit = ~chain_q[LAST] & prev_q;
      default:   hit = 1'b0;
    endcase
  end

  assign level_o = chain_q[LAST];
  assign edge_o  = qual_en_i & hit;

  p_edge_quiet_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !qual_en_i |-> !edge_o);
  p_edge_matches_pol_r3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |-> (level_o != prev_q) && (level_o == !edge_fall_i));
endmodule

// File: rtl/cmp_evt_flag.sv
module cmp_evt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic fwd_en_i,
  output logic flag_o,
  output logic pulse_o
);
  logic flag_q;
  logic fwd_q;
  logic fwd_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (set_i) begin
      flag_q <= 1'b1;
    end else if (clr_i) begin
      flag_q <= 1'b0;
    end
  end

  assign fwd_now = flag_q & fwd_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fwd_q <= 1'b0;
    else        fwd_q <= fwd_now;
  end

  assign flag_o  = flag_q;
  assign pulse_o = fwd_now & ~fwd_q;

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && !clr_i |=> flag_o);
  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/cmp_sel_decode.sv
module cmp_sel_decode #(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned NUM_SW = 8
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [NUM_SW-1:0] sw_en_o
);
  for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
    localparam logic [CODE_W-1:0] MATCH = CODE_W'(i + 1);
    assign sw_en_o[i] = (code_i == MATCH);
  end

  always_comb begin
    if (!$isunknown(code_i)) begin
      p_onehot_sel_r9: assert ($onehot0(sw_en_o));
    end
  end
endmodule

// File: rtl/cmp_evt_ctrl.sv
module cmp_evt_ctrl
  import cmp_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_edge_fall,
  input  logic              cfg_evt_en,
  input  logic              cfg_wake_en,
  input  logic              cfg_pin_en,
  input  logic [PSEL_W-1:0] cfg_psel,
  input  logic [NSEL_W-1:0] cfg_nsel,
  input  logic              flag_clr,
  input  logic              cmp_raw,
  output logic              flag_o,
  output logic              evt_pulse_o,
  output logic              wake_req_o,
  output logic              pin_o,
  output logic              raw_level_o,
  output logic [PSEL_N-1:0] psw_en_o,
  output logic [NSEL_N-1:0] nsw_en_o
);
  logic level;
  logic edge_hit;

  cmp_sync_edge #(.STAGES(SYNC_LEN)) u_sync_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .raw_i      (cmp_raw),
    .qual_en_i  (cfg_enable),
    .edge_fall_i(cfg_edge_fall),
    .level_o    (level),
    .edge_o     (edge_hit)
  );

  cmp_evt_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (edge_hit),
    .clr_i   (flag_clr),
    .fwd_en_i(cfg_enable & cfg_evt_en),
    .flag_o  (flag_o),
    .pulse_o (evt_pulse_o)
  );

  cmp_sel_decode #(.CODE_W(PSEL_W), .NUM_SW(PSEL_N)) u_pdec (
    .code_i (cfg_psel),
    .sw_en_o(psw_en_o)
  );

  cmp_sel_decode #(.CODE_W(NSEL_W), .NUM_SW(NSEL_N)) u_ndec (
    .code_i (cfg_nsel),
    .sw_en_o(nsw_en_o)
  );

  assign raw_level_o = level;
  assign wake_req_o  = cfg_enable & cfg_wake_en & level;
  assign pin_o       = cfg_enable & cfg_pin_en & level;

  p_flag_needs_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(cfg_enable));
  p_pulse_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse_o |-> flag_o && cfg_evt_en);
  p_outputs_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |-> !evt_pulse_o && !wake_req_o && !pin_o);
  p_wake_follows_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req_o |-> raw_level_o);
endmodule

// File: tb/cmp_evt_ctrl_tb.sv
module cmp_evt_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_enable = 1'b0, cfg_edge_fall = 1'b0, cfg_evt_en = 1'b0;
  logic       cfg_wake_en = 1'b0, cfg_pin_en = 1'b0;
  logic [3:0] cfg_psel = '0;
  logic [2:0] cfg_nsel = '0;
  logic       flag_clr = 1'b0, cmp_raw = 1'b0;
  logic       flag_o, evt_pulse_o, wake_req_o, pin_o, raw_level_o;
  logic [7:0] psw_en_o;
  logic [3:0] nsw_en_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  cmp_evt_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_edge_fall(cfg_edge_fall),
    .cfg_evt_en(cfg_evt_en), .cfg_wake_en(cfg_wake_en), .cfg_pin_en(cfg_pin_en),
    .cfg_psel(cfg_psel), .cfg_nsel(cfg_nsel), .flag_clr(flag_clr), .cmp_raw(cmp_raw),
    .flag_o(flag_o), .evt_pulse_o(evt_pulse_o), .wake_req_o(wake_req_o), .pin_o(pin_o),
    .raw_level_o(raw_level_o), .psw_en_o(psw_en_o), .nsw_en_o(nsw_en_o)
  );

  // {psel, expected psw, nsel, expected nsw}
  localparam logic [18:0] SEL_TAB [16] = '{
    {4'd0,  8'h00, 3'd0, 4'h0}, {4'd1,  8'h01, 3'd1, 4'h1},
    {4'd2,  8'h02, 3'd2, 4'h2}, {4'd3,  8'h04, 3'd3, 4'h4},
    {4'd4,  8'h08, 3'd4, 4'h8}, {4'd5,  8'h10, 3'd5, 4'h0},
    {4'd6,  8'h20, 3'd6, 4'h0}, {4'd7,  8'h40, 3'd7, 4'h0},
    {4'd8,  8'h80, 3'd0, 4'h0}, {4'd9,  8'h00, 3'd1, 4'h1},
    {4'd10, 8'h00, 3'd2, 4'h2}, {4'd11, 8'h00, 3'd3, 4'h4},
    {4'd12, 8'h00, 3'd4, 4'h8}, {4'd13, 8'h00, 3'd5, 4'h0},
    {4'd14, 8'h00, 3'd6, 4'h0}, {4'd15, 8'h00, 3'd7, 4'h0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R12 reset state
    chk({flag_o, evt_pulse_o, wake_req_o, pin_o, raw_level_o} == 5'b0, "R12",
        {flag_o, evt_pulse_o, wake_req_o, pin_o, raw_level_o}, 0);

    // R9 / R10 select decode table
    for (int i = 0; i < 16; i++) begin
      cfg_psel = SEL_TAB[i][18:15];
      cfg_nsel = SEL_TAB[i][6:4];
      #1;
      chk(psw_en_o == SEL_TAB[i][14:7], "R9", psw_en_o, SEL_TAB[i][14:7]);
      chk(nsw_en_o == SEL_TAB[i][3:0], "R10", nsw_en_o, SEL_TAB[i][3:0]);
    end

    // R11: disabled, rising edge ignored, outputs quiet
    cfg_wake_en = 1'b1; cfg_pin_en = 1'b1; cfg_evt_en = 1'b1;
    cmp_raw = 1'b1;
    tick(4);
    chk(!flag_o, "R11", flag_o, 0);
    chk(!wake_req_o && !pin_o && !evt_pulse_o, "R11",
        {wake_req_o, pin_o, evt_pulse_o}, 0);
    chk(raw_level_o, "R8", raw_level_o, 1);
    cmp_raw = 1'b0;
    tick(4);

    // R1 rising edge, R5 pulse, R6/R7/R8 levels
    cfg_enable = 1'b1;
    tick(1);
    cmp_raw = 1'b1;
    tick(1);
    chk(!raw_level_o, "R8", raw_level_o, 0);
    tick(1);
    chk(raw_level_o && wake_req_o && pin_o, "R6", {raw_level_o, wake_req_o, pin_o}, 7);
    chk(!flag_o, "R1", flag_o, 0);
    tick(1);
    chk(flag_o, "R1", flag_o, 1);
    chk(evt_pulse_o, "R5", evt_pulse_o, 1);
    tick(1);
    chk(!evt_pulse_o, "R5", evt_pulse_o, 0);
    cfg_pin_en = 1'b0;
    #1;
    chk(!pin_o && wake_req_o, "R7", {pin_o, wake_req_o}, 1);
    cfg_pin_en = 1'b1;

    // R4 sticky then clear
    tick(5);
    chk(flag_o, "R4", flag_o, 1);
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;
    chk(!flag_o, "R4", flag_o, 0);

    // R3 falling edge ignored in rising mode
    cmp_raw = 1'b0;
    tick(5);
    chk(!flag_o, "R3", flag_o, 0);

    // R2 falling mode, with clear coincident with the set (R4)
    cfg_edge_fall = 1'b1;
    cmp_raw = 1'b1;
    tick(5);
    chk(!flag_o, "R3", flag_o, 0);
    cmp_raw = 1'b0;
    tick(2);
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;
    chk(flag_o, "R4", flag_o, 1);
    chk(flag_o, "R2", flag_o, 1);
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;

    // R5: no pulse with event enable off
    cfg_evt_en = 1'b0;
    cmp_raw = 1'b1;
    tick(3);
    cmp_raw = 1'b0;
    tick(2);
    chk(!flag_o, "R2", flag_o, 0);
    tick(1);
    chk(flag_o && !evt_pulse_o, "R5", {flag_o, evt_pulse_o}, 2);
    // R5: pulse when enabled later with flag already set
    cfg_evt_en = 1'b1;
    #1;
    chk(evt_pulse_o, "R5", evt_pulse_o, 1);
    tick(1);
    chk(!evt_pulse_o, "R5", evt_pulse_o, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule